// File: doc/BRIEF.md
# Byte-Stuffing Frame Transmitter

This block turns packets that arrive one byte at a time into a line stream for an asynchronous serial link. Each packet is wrapped in flag bytes. Any payload byte that could be mistaken for a flag, or for the escape marker, is replaced by an escape pair, so a receiver that loses its place can recover at the next flag. Bytes arrive on a valid/ready input that carries a last marker on the final byte of a packet. Line bytes leave on a valid/ready output. A 32-bit run-time mask adds chosen control codes (0x00 to 0x1F) to the set of bytes that get escaped. A frame check sequence, if the packet has one, reaches the block as ordinary payload bytes.

The sequencer has four states:
- `ST_IDLE` offers the opening flag while an input byte is waiting. It moves to `ST_BODY` when that flag is taken.
- `ST_BODY` passes payload bytes through, or sends the escape marker for a reserved byte. It moves to `ST_ESC_TAIL` after an escape marker, and to `ST_CLOSE` after a plain last byte.
- `ST_ESC_TAIL` sends the modified second byte of the pair. It moves to `ST_CLOSE` if that byte was the last of the packet, and otherwise back to `ST_BODY`.
- `ST_CLOSE` sends the closing flag and returns to `ST_IDLE`.

A packet of N bytes, E of them reserved, therefore takes N + E + 2 line bytes.

Top module: `hdlc_octet_stuffer`

## Requirements
- R1: After reset, and whenever no packet is in progress and no input byte is offered, out_valid is 0 and in_ready is 0.
- R2: Before the first byte of each packet, the opening flag 0x7E is offered on the output. in_ready stays 0 while any flag is offered.
- R3: A payload byte that needs no escape is sent unchanged as one output byte, in the same cycle in which it is accepted.
- R4: A payload byte 0x7E is sent as 0x7D and then 0x5E.
- R5: A payload byte 0x7D is sent as 0x7D and then 0x5D.
- R6: A payload byte k in the range 0x00 to 0x1F is sent as 0x7D and then k XOR 0x20 when bit k of esc_map is 1. It is sent unchanged when bit k is 0.
- R7: While the second byte of an escape pair is offered, in_ready is 0. The escaped byte itself is accepted in the cycle its 0x7D marker is sent.
- R8: After the output bytes of the byte marked last, including its escape pair if it has one, a closing 0x7E is sent.
- R9: While out_valid is 1 and out_ready is 0, the output byte stays the same in the next cycle, and out_valid stays 1.
- R10: esc_map has no effect on bytes 0x20 and above. With all mask bits set, such bytes other than 0x7D and 0x7E are still sent unchanged.
- R11: Packets sent back to back each get their own opening and closing flag, so two flags appear between them. A packet of one byte is framed like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| esc_map | input | 32 | Bit k set: byte value k is also escaped |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is offered |
| in_last | input | 1 | Offered byte is the last of its packet |
| in_ready | output | 1 | Payload byte is accepted this cycle |
| out_data | output | 8 | Line byte |
| out_valid | output | 1 | Line byte is offered |
| out_ready | input | 1 | Line byte is taken this cycle |

## Verification
The output-hold property relies on the input side following valid/ready rules: once in_valid is raised, in_data, in_last and in_valid stay unchanged until the byte is accepted. The output is passed straight through from the input in `ST_IDLE` and `ST_BODY`, so this rule is needed. The esc_map input is also assumed to change only between packets. The bench driver raises a byte and leaves it untouched until it sees in_ready high before a rising edge. It changes the mask only while the block is idle. The stalls on out_ready follow a fixed repeating pattern that covers flags, escape markers and escape tails.

// File: rtl/hdlc_stuff_pkg.sv
package hdlc_stuff_pkg;
    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  FLAG_VAL = 8'h7E;
    localparam logic [7:0]  ESC_VAL  = 8'h7D;
    localparam logic [7:0]  FLIP_VAL = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_ESC_TAIL,
        ST_CLOSE
    } stuff_state_t;
endpackage

// File: rtl/hdlc_esc_detect.sv
module hdlc_esc_detect #(
    parameter int MAP_W = 32
) (
    input  logic [7:0]       byte_i,
    input  logic [MAP_W-1:0] map_i,
    output logic             needs_esc_o
);
    import hdlc_stuff_pkg::*;

    localparam int IDX_W = hdlc_stuff_pkg::BYTE_W;

    logic [MAP_W-1:0] ctrl_hit;

    // One comparator per mask bit; the mask picks which ones count.
    generate
        for (genvar k = 0; k < MAP_W; k++) begin : g_ctrl
            assign ctrl_hit[k] = map_i[k] & (byte_i == IDX_W'(k));
        end
    endgenerate

    assign needs_esc_o = (|ctrl_hit) | (byte_i == FLAG_VAL) | (byte_i == ESC_VAL);
endmodule

// File: rtl/hdlc_tail_reg.sv
module hdlc_tail_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    input  logic       last_i,
    output logic [7:0] byte_o,
    output logic       last_o
);
    import hdlc_stuff_pkg::*;

    // Holds the second byte of an escape pair, already modified.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_o <= '0;
            last_o <= 1'b0;
        end else if (load_i) begin
            byte_o <= byte_i ^ FLIP_VAL;
            last_o <= last_i;
        end
    end
endmodule

// File: rtl/hdlc_octet_stuffer.sv
module hdlc_octet_stuffer #(
    parameter int MAP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAP_W-1:0] esc_map,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready
);
    import hdlc_stuff_pkg::*;

    stuff_state_t state_q, state_d;
    logic         needs_esc;
    logic         tail_load;
    logic [7:0]   tail_byte;
    logic         tail_last;

    hdlc_esc_detect #(.MAP_W(MAP_W)) u_detect (
        .byte_i      (in_data),
        .map_i       (esc_map),
        .needs_esc_o (needs_esc)
    );

    hdlc_tail_reg u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tail_load),
        .byte_i (in_data),
        .last_i (in_last),
        .byte_o (tail_byte),
        .last_o (tail_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        out_valid = 1'b0;
        out_data  = FLAG_VAL;
        in_ready  = 1'b0;
        tail_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // Opening flag offered only once a packet byte is waiting.
                out_valid = in_valid;
                out_data  = FLAG_VAL;
                if (in_valid && out_ready) state_d = ST_BODY;
            end
            ST_BODY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = needs_esc ? ESC_VAL : in_data;
                if (in_valid && out_ready) begin
                    if (needs_esc) begin
                        tail_load = 1'b1;
                        state_d   = ST_ESC_TAIL;
                    end else if (in_last) begin
                        state_d = ST_CLOSE;
                    end
                end
            end
            ST_ESC_TAIL: begin
                out_valid = 1'b1;
                out_data  = tail_byte;
                if (out_ready) state_d = tail_last ? ST_CLOSE : ST_BODY;
            end
            ST_CLOSE: begin
                out_valid = 1'b1;
                out_data  = FLAG_VAL;
                if (out_ready) state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/hdlc_stuff_chk.sv
module hdlc_stuff_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] in_data,
    input logic       in_valid,
    input logic       in_last,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready
);
    AST_FLAG_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data == 8'h7E) |-> !in_ready); // R2

    AST_ACCEPT_MOVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready)); // R3

    AST_ESC_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == 8'h7D) |=>
        (out_valid && !in_ready &&
         (out_data == 8'h5E || out_data == 8'h5D || out_data[7:5] == 3'b001))); // R7

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && out_data != 8'h7D) |=>
        (out_valid && out_data == 8'h7E)); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
endmodule

bind hdlc_octet_stuffer hdlc_stuff_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/hdlc_octet_stuffer_tb_top.sv
module hdlc_octet_stuffer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] esc_map = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    logic       stall_en = 1'b0;
    int         stall_cnt = 0;
    logic [7:0] pkt [0:15];
    logic [7:0] exp_q [$];
    logic [7:0] cap_q [$];

    // monitor state
    logic       tail_pend = 1'b0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    int         tail_viol = 0, tail_seen = 0, hold_viol = 0, hold_seen = 0, flag_viol = 0;

    always #5 clk = ~clk;

    hdlc_octet_stuffer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .esc_map   (esc_map),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    // Output stall pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        stall_cnt = stall_cnt + 1;
        out_ready = stall_en ? ((stall_cnt % 3) != 0) : 1'b1;
    end

    // Monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                hold_seen = hold_seen + 1;
                if (!(out_valid && out_data == prev_data)) hold_viol = hold_viol + 1;
            end
            if (tail_pend && out_valid) begin
                tail_seen = tail_seen + 1;
                if (in_ready) tail_viol = tail_viol + 1;
            end
            if (out_valid && out_data == 8'h7E && in_ready) flag_viol = flag_viol + 1;
            if (out_valid && out_ready) begin
                cap_q.push_back(out_data);
                tail_pend = (out_data == 8'h7D) && !tail_pend;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected line bytes for one payload byte, from the requirements.
    task automatic exp_byte(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D || (b < 8'h20 && esc_map[b[4:0]])) begin
            exp_q.push_back(8'h7D);
            exp_q.push_back(b ^ 8'h20);
        end else begin
            exp_q.push_back(b);
        end
    endtask

    task automatic expect_pkt(input int n);
        exp_q.push_back(8'h7E);
        for (int i = 0; i < n; i++) exp_byte(pkt[i]);
        exp_q.push_back(8'h7E);
    endtask

    task automatic drive_pkt(input int n);
        for (int i = 0; i < n; i++) begin
            in_data  = pkt[i];
            in_last  = (i == n - 1);
            in_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain_and_compare(input string req);
        for (int i = 0; i < 2000 && cap_q.size() < exp_q.size(); i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(cap_q.size() == exp_q.size(), req, "stream length", cap_q.size(), exp_q.size());
        if (cap_q.size() == exp_q.size()) begin
            for (int i = 0; i < exp_q.size(); i++) begin
                if (cap_q[i] != exp_q[i]) begin
                    check(1'b0, req, $sformatf("byte %0d", i), cap_q[i], exp_q[i]);
                    break;
                end
            end
        end
        check(!out_valid && !in_ready, "R1", "idle after packet", {out_valid, in_ready}, 0);
        exp_q.delete();
        cap_q.delete();
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        check(!in_ready, "R1", "in_ready after reset", in_ready, 0);
    endtask

    task automatic test_plain();
        pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'hA5; pkt[3] = 8'h3C;
        expect_pkt(4);
        drive_pkt(4);
        check(cap_q.size() > 0 && cap_q[0] == 8'h7E, "R2", "opening flag",
              cap_q.size() > 0 ? cap_q[0] : 0, 8'h7E);
        drain_and_compare("R3 R8");
    endtask

    task automatic test_reserved();
        pkt[0] = 8'h7E; pkt[1] = 8'h01; pkt[2] = 8'h7D; pkt[3] = 8'h7E;
        expect_pkt(4);
        drive_pkt(4);
        drain_and_compare("R4 R5 R8");
    endtask

    task automatic test_ctrl_map();
        esc_map = 32'h000A_0002; // bits 1, 17, 19
        pkt[0] = 8'h00; pkt[1] = 8'h01; pkt[2] = 8'h11; pkt[3] = 8'h13;
        pkt[4] = 8'h1F; pkt[5] = 8'h20;
        expect_pkt(6);
        drive_pkt(6);
        check(cap_q.size() > 3 && cap_q[2] == 8'h7D && cap_q[3] == 8'h21, "R6",
              "0x01 escaped", cap_q.size() > 3 ? cap_q[3] : 0, 8'h21);
        drain_and_compare("R6");
        esc_map = '0;
    endtask

    task automatic test_map_high();
        esc_map = 32'hFFFF_FFFF;
        pkt[0] = 8'h41; pkt[1] = 8'hE0; pkt[2] = 8'hFF; pkt[3] = 8'h20; pkt[4] = 8'h9E;
        expect_pkt(5);
        drive_pkt(5);
        drain_and_compare("R10");
        esc_map = '0;
    endtask

    task automatic test_stall();
        stall_en = 1'b1;
        esc_map  = 32'h0000_0008;
        pkt[0] = 8'h7D; pkt[1] = 8'h03; pkt[2] = 8'h55; pkt[3] = 8'h7E; pkt[4] = 8'h7E;
        expect_pkt(5);
        drive_pkt(5);
        drain_and_compare("R9");
        stall_en = 1'b0;
        esc_map  = '0;
        @(negedge clk);
    endtask

    task automatic test_back_to_back();
        pkt[0] = 8'h7E;
        expect_pkt(1);
        drive_pkt(1);
        pkt[0] = 8'h55;
        expect_pkt(1);
        drive_pkt(1);
        drain_and_compare("R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        test_plain();
        test_reserved();
        test_ctrl_map();
        test_map_high();
        test_stall();
        test_back_to_back();
        check(tail_seen > 0 && tail_viol == 0, "R7", "in_ready low during escape tail",
              tail_viol, 0);
        check(hold_seen > 0 && hold_viol == 0, "R9", "output held while stalled",
              hold_viol, 0);
        check(flag_viol == 0, "R2", "in_ready low while flag offered", flag_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule